// File: doc/BRIEF.md
# Pipelined Shift-Subtract Integer Divider

This block divides one scalar integer operand by another and returns the quotient after a fixed number of clock cycles. Each pair of operands comes with a strobe. A per-pair mode input selects how both operands are read: as unsigned numbers or as two's-complement numbers. Every pipeline stage resolves one quotient bit. It shifts the running remainder left and then either subtracts or adds the divisor, based on the remainder's current sign, and no restore step is taken. A final stage turns the recorded add/subtract decisions into the exact quotient.

The result is always rounded toward zero. A quotient that does not fit the word is clamped to the largest value instead of wrapping. A zero divisor gives a clamped value and raises a flag. A new operand pair can enter on every clock, and results leave in the same order the pairs entered. The block is meant to sit in a datapath that can absorb a known, constant delay.

Top module: `nrdiv_pipe`

## Requirements
- R1: With `op_signed` = 0 and a non-zero divisor, `quotient` is the integer part of `dividend / divisor`, both read as unsigned W-bit numbers.
- R2: With `op_signed` = 1 and a non-zero divisor, both operands are read as two's complement. `quotient` is the exact quotient rounded toward zero, so its sign is the XOR of the operand signs unless the result is zero.
- R3: In signed mode, the one case whose true quotient exceeds the range (most negative dividend divided by -1) returns the largest positive value, 2^(W-1)-1, and never wraps.
- R4: A zero divisor sets `div_by_zero` = 1 alongside the result. The result is then all ones in unsigned mode. In signed mode it is 2^(W-1)-1 for a non-negative dividend and 2^(W-1) (most negative) for a negative one. `div_by_zero` is 0 for any non-zero divisor.
- R5: `out_valid` rises exactly W+4 clock cycles after the cycle in which `in_valid` was sampled high. This latency is the same in both modes.
- R6: Pairs may be presented on consecutive cycles. Each accepted pair gives exactly one result, and results come out in acceptance order.
- R7: Cycles with `in_valid` = 0 produce no result. Whenever `out_valid` is 0, `quotient` and `div_by_zero` are both 0.
- R8: While `rst_n` is low, and after it is released until the first result, `out_valid`, `quotient` and `div_by_zero` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_signed | input | 1 | 1: operands are two's complement; 0: unsigned |
| dividend | input | W | Numerator |
| divisor | input | W | Denominator |
| out_valid | output | 1 | Result present this cycle |
| quotient | output | W | Quotient, rounded toward zero and clamped |
| div_by_zero | output | 1 | Result came from a zero divisor |

## Verification
The stages keep no state from one pair to the next. A corrupted remainder, add/subtract choice or quotient bit in any stage therefore shows up only in the result slot of the pair that held it, exactly W+4 cycles after that pair entered. It appears as a wrong magnitude or a wrong final bit. A wrong sign flag, signed-mode flag or zero flag shows at that same slot as a wrong sign, a missing clamp or a wrong `div_by_zero`. A bit error in the valid chain shows as a missing, early or extra strobe. Streaming pairs back to back shows any such error immediately, as a mismatch against the ordered list of expected results.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    // Per-pair control that travels alongside the datapath
    typedef struct packed {
        logic vld;      // slot holds a pair
        logic sgn;      // two's-complement interpretation
        logic dvd_neg;  // dividend was negative (signed mode only)
        logic q_neg;    // quotient must be negated (signed mode only)
        logic dz;       // divisor was zero
    } ctl_t;

    localparam int unsigned PRE_STAGES  = 2;
    localparam int unsigned POST_STAGES = 2;

endpackage

// File: rtl/nrdiv_prep.sv
module nrdiv_prep
    import nrdiv_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         op_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output ctl_t         ctl_o,
    output logic [W-1:0] dvd_mag_o,
    output logic [W-1:0] dvs_mag_o
);

    typedef struct packed {
        logic         vld;
        logic         sgn;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } raw_t;

    typedef struct packed {
        ctl_t         ctl;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } mag_t;

    raw_t raw_d, raw_q;
    mag_t mag_d, mag_q;

    always_comb begin
        logic a_neg;
        logic b_neg;
        raw_d.vld = in_valid;
        raw_d.sgn = op_signed;
        raw_d.a   = dividend;
        raw_d.b   = divisor;

        a_neg = raw_q.sgn & raw_q.a[W-1];
        b_neg = raw_q.sgn & raw_q.b[W-1];
        mag_d.ctl.vld     = raw_q.vld;
        mag_d.ctl.sgn     = raw_q.sgn;
        mag_d.ctl.dvd_neg = a_neg;
        mag_d.ctl.q_neg   = a_neg ^ b_neg;
        mag_d.ctl.dz      = (raw_q.b == '0);
        // The most negative value maps onto 2^(W-1), which still fits W bits
        mag_d.a = a_neg ? (~raw_q.a + 1'b1) : raw_q.a;
        mag_d.b = b_neg ? (~raw_q.b + 1'b1) : raw_q.b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            mag_q <= '0;
        end else begin
            raw_q <= raw_d;
            mag_q <= mag_d;
        end
    end

    assign ctl_o     = mag_q.ctl;
    assign dvd_mag_o = mag_q.a;
    assign dvs_mag_o = mag_q.b;

endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step
    import nrdiv_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl_i,
    input  logic [W-1:0]  dvs_i,
    input  logic [W+1:0]  rem_i,
    input  logic [W-1:0]  qbits_i,
    output ctl_t          ctl_o,
    output logic [W-1:0]  dvs_o,
    output logic [W+1:0]  rem_o,
    output logic [W-1:0]  qbits_o
);

    localparam int unsigned RW = W + 2;

    typedef struct packed {
        ctl_t          ctl;
        logic [W-1:0]  dvs;
        logic [RW-1:0] rem;
        logic [W-1:0]  qb;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic          take_sub;
        logic [RW-1:0] shifted;
        logic [RW-1:0] dext;
        // Subtract while the remainder is non-negative, add back otherwise
        take_sub = ~rem_i[RW-1];
        shifted  = {rem_i[RW-2:0], qbits_i[W-1]};
        dext     = {2'b00, dvs_i};
        st_d.ctl = ctl_i;
        st_d.dvs = dvs_i;
        st_d.rem = take_sub ? (shifted - dext) : (shifted + dext);
        // Dividend bits leave at the top, decision bits enter at the bottom
        st_d.qb  = {qbits_i[W-2:0], take_sub};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o   = st_q.ctl;
    assign dvs_o   = st_q.dvs;
    assign rem_o   = st_q.rem;
    assign qbits_o = st_q.qb;

endmodule

// File: rtl/nrdiv_post.sv
module nrdiv_post
    import nrdiv_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctl_t         ctl_i,
    input  logic         rem_neg_i,
    input  logic [W-2:0] qbits_i,
    output logic         out_valid,
    output logic [W-1:0] quotient,
    output logic         div_by_zero
);

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

    typedef struct packed {
        ctl_t         ctl;
        logic [W-1:0] mag;
    } fix_t;

    typedef struct packed {
        logic         vld;
        logic         dz;
        logic [W-1:0] q;
    } res_t;

    fix_t fix_d, fix_q;
    res_t res_d, res_q;

    always_comb begin
        // Decision bits P give 2P-(2^W-1); a negative final remainder takes
        // one away. Modulo 2^W this is P shifted up with the inverted sign.
        fix_d.ctl = ctl_i;
        fix_d.mag = {qbits_i, ~rem_neg_i};

        res_d = '0;
        if (fix_q.ctl.vld) begin
            res_d.vld = 1'b1;
            res_d.dz  = fix_q.ctl.dz;
            if (fix_q.ctl.dz) begin
                if (!fix_q.ctl.sgn)         res_d.q = ALL_ONE;
                else if (fix_q.ctl.dvd_neg) res_d.q = MIN_NEG;
                else                        res_d.q = MAX_POS;
            end else if (fix_q.ctl.sgn && fix_q.ctl.q_neg) begin
                res_d.q = ~fix_q.mag + 1'b1;
            end else if (fix_q.ctl.sgn && (fix_q.mag > MAX_POS)) begin
                res_d.q = MAX_POS;
            end else begin
                res_d.q = fix_q.mag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fix_q <= '0;
            res_q <= '0;
        end else begin
            fix_q <= fix_d;
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.vld;
    assign quotient    = res_q.q;
    assign div_by_zero = res_q.dz;

endmodule

// File: rtl/nrdiv_pipe.sv
module nrdiv_pipe
    import nrdiv_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         op_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         out_valid,
    output logic [W-1:0] quotient,
    output logic         div_by_zero
);

    localparam int unsigned RW = W + 2;

    ctl_t          ctl_s [0:W];
    logic [W-1:0]  dvs_s [0:W];
    logic [W-1:0]  q_s   [0:W];
    logic [RW-1:0] rem_s [0:W];

    nrdiv_prep #(.W(W)) u_prep (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_signed (op_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .ctl_o     (ctl_s[0]),
        .dvd_mag_o (q_s[0]),
        .dvs_mag_o (dvs_s[0])
    );

    assign rem_s[0] = '0;

    for (genvar k = 0; k < W; k++) begin : g_iter
        nrdiv_step #(.W(W)) u_step (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_i   (ctl_s[k]),
            .dvs_i   (dvs_s[k]),
            .rem_i   (rem_s[k]),
            .qbits_i (q_s[k]),
            .ctl_o   (ctl_s[k+1]),
            .dvs_o   (dvs_s[k+1]),
            .rem_o   (rem_s[k+1]),
            .qbits_o (q_s[k+1])
        );
    end

    nrdiv_post #(.W(W)) u_post (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_i       (ctl_s[W]),
        .rem_neg_i   (rem_s[W][RW-1]),
        .qbits_i     (q_s[W][W-2:0]),
        .out_valid   (out_valid),
        .quotient    (quotient),
        .div_by_zero (div_by_zero)
    );

endmodule

// File: rtl/nrdiv_chk.sv
module nrdiv_chk
    import nrdiv_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         op_signed,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         out_valid,
    input logic [W-1:0] quotient,
    input logic         div_by_zero
);

    localparam int unsigned LAT = W + PRE_STAGES + POST_STAGES;

    typedef struct packed {
        logic         vld;
        logic         sgn;
        logic         zero_b;
        logic         neg_exp;
        logic [W-1:0] a;
    } mon_t;

    mon_t sr [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) sr[i] <= '0;
        end else begin
            sr[0].vld     <= in_valid;
            sr[0].sgn     <= op_signed;
            sr[0].zero_b  <= (divisor == '0);
            sr[0].neg_exp <= op_signed & (dividend[W-1] ^ divisor[W-1]);
            sr[0].a       <= dividend;
            for (int i = 1; i < LAT; i++) sr[i] <= sr[i-1];
        end
    end

    // R5 / R6: one strobe per accepted pair, fixed delay
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == sr[LAT-1].vld);

    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (div_by_zero == sr[LAT-1].zero_b));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (quotient == '0 && !div_by_zero));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sr[LAT-1].sgn && !sr[LAT-1].zero_b && quotient != '0)
        |-> (quotient[W-1] == sr[LAT-1].neg_exp));

    a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sr[LAT-1].sgn && !sr[LAT-1].zero_b)
        |-> (quotient <= sr[LAT-1].a));

endmodule

bind nrdiv_pipe nrdiv_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_signed   (op_signed),
    .dividend    (dividend),
    .divisor     (divisor),
    .out_valid   (out_valid),
    .quotient    (quotient),
    .div_by_zero (div_by_zero)
);

// File: tb/sim_nrdiv_pipe.sv
module sim_nrdiv_pipe;

    localparam int W   = 8;
    localparam int LAT = W + 4;
    localparam int QD  = 1024;

    localparam logic [W-1:0] MAX_POS = 8'h7F;
    localparam logic [W-1:0] MIN_NEG = 8'h80;

    typedef struct packed {
        logic         sg;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] q;
        logic         dz;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd100, 8'd7,   8'h0E, 1'b0},
        '{1'b0, 8'd255, 8'd1,   8'hFF, 1'b0},
        '{1'b0, 8'd255, 8'd255, 8'h01, 1'b0},
        '{1'b0, 8'd3,   8'd200, 8'h00, 1'b0},
        '{1'b0, 8'd0,   8'd5,   8'h00, 1'b0},
        '{1'b0, 8'd200, 8'd0,   8'hFF, 1'b1},
        '{1'b0, 8'd0,   8'd0,   8'hFF, 1'b1},
        '{1'b1, 8'd100, 8'd7,   8'h0E, 1'b0},
        '{1'b1, 8'h9C,  8'd7,   8'hF2, 1'b0},
        '{1'b1, 8'd100, 8'hF9,  8'hF2, 1'b0},
        '{1'b1, 8'h9C,  8'hF9,  8'h0E, 1'b0},
        '{1'b1, 8'h80,  8'hFF,  8'h7F, 1'b0},
        '{1'b1, 8'h80,  8'h01,  8'h80, 1'b0},
        '{1'b1, 8'h7F,  8'h80,  8'h00, 1'b0},
        '{1'b1, 8'h80,  8'h80,  8'h01, 1'b0},
        '{1'b1, 8'hF9,  8'h02,  8'hFD, 1'b0},
        '{1'b1, 8'h05,  8'h00,  8'h7F, 1'b1},
        '{1'b1, 8'hFB,  8'h00,  8'h80, 1'b1},
        '{1'b1, 8'h00,  8'h00,  8'h7F, 1'b1},
        '{1'b0, 8'h80,  8'hFF,  8'h00, 1'b0},
        '{1'b1, 8'h01,  8'hFF,  8'hFF, 1'b0},
        '{1'b0, 8'hFE,  8'h02,  8'h7F, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         out_valid;
    logic [W-1:0] quotient;
    logic         div_by_zero;

    int n_chk = 0;
    int n_bad = 0;
    int wr_idx = 0;
    int rd_idx = 0;
    logic [W-1:0] exp_q   [QD];
    logic         exp_dz  [QD];
    string        exp_tag [QD];

    always #4 clk = ~clk;

    nrdiv_pipe #(.W(W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .op_signed   (op_signed),
        .dividend    (dividend),
        .divisor     (divisor),
        .out_valid   (out_valid),
        .quotient    (quotient),
        .div_by_zero (div_by_zero)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W:0] ref_div(input logic sg, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        int sa, sb, r;
        if (b == '0) begin
            if (!sg)        return {1'b1, {W{1'b1}}};
            else if (a[W-1]) return {1'b1, MIN_NEG};
            else             return {1'b1, MAX_POS};
        end
        if (!sg) return {1'b0, a / b};
        sa = $signed(a);
        sb = $signed(b);
        r  = sa / sb;
        if (r > 127) r = 127;
        return {1'b0, r[W-1:0]};
    endfunction

    // Drive one pair at a falling edge and record what must come out
    task automatic apply(input logic sg, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] q, input logic dz, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        op_signed = sg;
        dividend  = a;
        divisor   = b;
        exp_q[wr_idx]   = q;
        exp_dz[wr_idx]  = dz;
        exp_tag[wr_idx] = tag;
        wr_idx++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            dividend = 8'hA5 ^ W'(i);
            divisor  = W'(i);
            op_signed = i[0];
        end
    endtask

    // Result monitor: ordering (R6), values, idle outputs (R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (rd_idx >= wr_idx) begin
                    check(1'b0, "R7", "unexpected result", int'(quotient), 0);
                end else begin
                    check(quotient == exp_q[rd_idx], exp_tag[rd_idx], "quotient",
                          int'(quotient), int'(exp_q[rd_idx]));
                    check(div_by_zero == exp_dz[rd_idx], "R4", "div_by_zero",
                          int'(div_by_zero), int'(exp_dz[rd_idx]));
                    rd_idx++;
                end
            end else begin
                check(quotient == '0 && !div_by_zero, "R7", "idle outputs",
                      int'({div_by_zero, quotient}), 0);
            end
        end
    end

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", "timeout", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W:0] r;
        int cyc;
        // R8: outputs quiet in reset and just after release
        repeat (3) @(negedge clk);
        check(!out_valid && quotient == '0 && !div_by_zero, "R8", "in reset",
              int'({out_valid, div_by_zero, quotient}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && quotient == '0 && !div_by_zero, "R8", "after reset",
              int'({out_valid, div_by_zero, quotient}), 0);

        // Table walk, back to back (R1-R4, R6)
        for (int i = 0; i < NV; i++) begin
            string tg;
            if (VECS[i].dz) tg = "R4";
            else if (VECS[i].sg && VECS[i].a == 8'h80 && VECS[i].b == 8'hFF) tg = "R3";
            else if (VECS[i].sg) tg = "R2";
            else tg = "R1";
            apply(VECS[i].sg, VECS[i].a, VECS[i].b, VECS[i].q, VECS[i].dz, tg);
        end
        idle(LAT + 3);

        // Sweep against a reference in both modes, streamed (R1, R2, R6)
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 256; a += 29) begin
                for (int b = 0; b < 256; b += 31) begin
                    r = ref_div(s[0], W'(a), W'(b));
                    apply(s[0], W'(a), W'(b), r[W-1:0], r[W],
                          (b == 0) ? "R4" : (s == 1 ? "R2" : "R1"));
                end
            end
        end
        idle(LAT + 3);

        // Operands with in_valid low must yield nothing (R7)
        idle(40);
        check(rd_idx == wr_idx, "R7", "results after idle", rd_idx, wr_idx);

        // Latency of a lone pair in each mode (R5)
        for (int s = 0; s < 2; s++) begin
            apply(s[0], 8'd90, 8'd9, 8'd10, 1'b0, "R5");
            cyc = 0;
            @(negedge clk);
            in_valid = 1'b0;
            cyc = 1;
            while (!out_valid && cyc < 4 * LAT) begin
                @(negedge clk);
                cyc++;
            end
            check(cyc == LAT, "R5", "latency", cyc, LAT);
            idle(4);
        end

        // Sparse pattern: valid every other cycle keeps order (R6)
        for (int i = 0; i < 8; i++) begin
            r = ref_div(1'b1, W'(-17 * i), W'(i - 3));
            apply(1'b1, W'(-17 * i), W'(i - 3), r[W-1:0], r[W], "R6");
            @(negedge clk);
            in_valid = 1'b0;
        end
        idle(LAT + 3);
        check(rd_idx == wr_idx, "R6", "result count", rd_idx, wr_idx);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule